// File: doc/BRIEF.md
# Bus Trace Trigger Matcher

This block sits beside a CPU bus and inspects every bus cycle the bus marks as valid. It fires a trigger when three conditions agree on the same cycle: the bus address equals one programmed address, the bus data equals a programmed 16-bit pattern on every bit not excluded by a per-bit mask, and the cycle's operation kind agrees with a programmed operation selector. Trace capture logic uses the trigger to mark the trigger point in its record, and a trigger-out pin carries a stretched pulse to equipment outside the chip.

The bus side is a monitor stream with a valid strobe only. An observer cannot stall the CPU, so there is no ready signal and no back-pressure: the block takes every cycle that has `bus_vld` high, whatever the cycle before it was. The configuration inputs are plain static levels. They are sampled on the same clock edge as the bus cycle they are compared against.

The trigger strobe is registered, so it appears one clock after the matching cycle. The trigger-out pulse has a programmable length. A new match restarts that length count.

Top module: `trig_matcher`

## Requirements
- R1: `trig_stb` is high for exactly the one clock that follows a clock edge at which `bus_vld` was high and all match conditions held. With `bus_vld` low it stays low, whatever the other inputs are.
- R2: A match requires `bus_addr` to equal `cfg_addr` on every bit. An address that differs in any bit gives no trigger.
- R3: The data condition holds when every bit position with `cfg_mask` bit = 0 has `bus_data` equal to `cfg_pattern`. A position with `cfg_mask` bit = 1 is excluded from the comparison.
- R4: With `cfg_mask` = 16'hFFFF the data condition is always true, whatever the values of `bus_data` and `cfg_pattern`.
- R5: `cfg_op` = 0 (any) accepts every value of `bus_op`.
- R6: The `cfg_op` codes 1 to 8 each accept only the equal `bus_op` code. The encoding is 1 instruction fetch, 2 vector fetch, 3 data read, 4 data write, 5 stack read, 6 stack write, 7 DMA read and 8 DMA write.
- R7: `cfg_op` codes 9 to 15 disable the trigger. Neither `trig_stb` nor `trig_out` ever rises while such a code is selected.
- R8: `trig_out` rises in the same clock as `trig_stb` and stays high for `cfg_plen_m1`+1 clocks (1 to 16). It never rises without `trig_stb`.
- R9: A match while `trig_out` is high restarts the count. `trig_out` then stays high for `cfg_plen_m1`+1 clocks counted from the new `trig_stb`.
- R10: During reset (`rst_n` low) and on the first clock after it, `trig_stb` and `trig_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_vld | input | 1 | Bus cycle valid |
| bus_addr | input | 32 | Bus address |
| bus_data | input | 16 | Bus data |
| bus_op | input | 4 | Bus operation kind (codes 1 to 8) |
| cfg_addr | input | 32 | Address to match |
| cfg_pattern | input | 16 | Data pattern |
| cfg_mask | input | 16 | Per-bit exclusion mask, 1 = ignore bit |
| cfg_op | input | 4 | Operation selector: 0 any, 1 to 8 exact, 9 to 15 disabled |
| cfg_plen_m1 | input | 4 | Trigger-out pulse length minus one |
| trig_stb | output | 1 | Single-clock trigger strobe for capture logic |
| trig_out | output | 1 | Stretched trigger-out pulse |

## Verification
The bench drives cycles that match on every condition but one: an address one away from the target, a single unmasked data bit flipped, and a wrong operation kind. A design that ORs the conditions together, or that compares masked bits, would fire on these cycles. The bench sweeps the any code across all eight operation kinds and checks that the disabled codes 9 and 15 stay silent, which catches a selector that wraps or decodes only the low three bits. It checks pulse lengths of 1 and 16, where an off-by-one design gives a pulse that is one clock short or long. It also re-matches in the middle of a pulse, where a design that ignores the restart drops `trig_out` too early.

// File: rtl/trig_match_pkg.sv
package trig_match_pkg;
  localparam int unsigned OP_W    = 4;
  localparam int unsigned OP_LAST = 8;

  typedef enum logic [OP_W-1:0] {
    OP_ANY    = 4'd0,
    OP_IFETCH = 4'd1,
    OP_VFETCH = 4'd2,
    OP_DRD    = 4'd3,
    OP_DWR    = 4'd4,
    OP_SRD    = 4'd5,
    OP_SWR    = 4'd6,
    OP_DMARD  = 4'd7,
    OP_DMAWR  = 4'd8
  } bus_op_e;
endpackage

// File: rtl/trig_field_cmp.sv
module trig_field_cmp #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 16
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_pattern,
  input  logic [DATA_W-1:0] cfg_mask,
  output logic              addr_hit,
  output logic              data_hit
);
  logic [DATA_W-1:0] bit_ok;

  // Each data lane passes if it is excluded or agrees with the pattern.
  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign bit_ok[i] = cfg_mask[i] | (bus_data[i] ~^ cfg_pattern[i]);
  end

  assign addr_hit = (bus_addr == cfg_addr);
  assign data_hit = &bit_ok;
endmodule

// File: rtl/trig_op_sel.sv
module trig_op_sel
  import trig_match_pkg::*;
(
  input  logic [OP_W-1:0] bus_op,
  input  logic [OP_W-1:0] cfg_op,
  output logic            op_hit
);
  logic [OP_LAST:1] code_hit;

  // One comparator per defined operation code; unlisted codes select nothing.
  for (genvar c = 1; c <= OP_LAST; c++) begin : g_code
    assign code_hit[c] = (cfg_op == OP_W'(c)) && (bus_op == OP_W'(c));
  end

  assign op_hit = (cfg_op == OP_ANY) || (|code_hit);
endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen #(
  parameter int unsigned PULSE_MAX = 16,
  localparam int unsigned LEN_W    = $clog2(PULSE_MAX),
  localparam int unsigned CNT_W    = $clog2(PULSE_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [LEN_W-1:0] len_m1,
  output logic             pulse
);
  logic [CNT_W-1:0] remain;

  // A fire reloads the full length, so the count restarts on every new fire.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (fire) begin
      remain <= CNT_W'(len_m1) + CNT_W'(1);
    end else if (remain != '0) begin
      remain <= remain - CNT_W'(1);
    end
  end

  assign pulse = (remain != '0);
endmodule

// File: rtl/trig_matcher.sv
module trig_matcher
  import trig_match_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PULSE_MAX = 16,
  localparam int unsigned LEN_W    = $clog2(PULSE_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_vld,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [OP_W-1:0]   bus_op,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_pattern,
  input  logic [DATA_W-1:0] cfg_mask,
  input  logic [OP_W-1:0]   cfg_op,
  input  logic [LEN_W-1:0]  cfg_plen_m1,
  output logic              trig_stb,
  output logic              trig_out
);
  logic addr_hit;
  logic data_hit;
  logic op_hit;
  logic cyc_match;
  logic stb_q;

  trig_field_cmp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_fields (
    .bus_addr    (bus_addr),
    .bus_data    (bus_data),
    .cfg_addr    (cfg_addr),
    .cfg_pattern (cfg_pattern),
    .cfg_mask    (cfg_mask),
    .addr_hit    (addr_hit),
    .data_hit    (data_hit)
  );

  trig_op_sel u_op (
    .bus_op (bus_op),
    .cfg_op (cfg_op),
    .op_hit (op_hit)
  );

  assign cyc_match = bus_vld && addr_hit && data_hit && op_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= cyc_match;
  end

  trig_pulse_gen #(
    .PULSE_MAX (PULSE_MAX)
  ) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (cyc_match),
    .len_m1 (cfg_plen_m1),
    .pulse  (trig_out)
  );

  assign trig_stb = stb_q;
endmodule

// File: rtl/trig_matcher_chk.sv
module trig_matcher_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PULSE_MAX = 16,
  localparam int unsigned LEN_W    = $clog2(PULSE_MAX)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_vld,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_data,
  input logic [3:0]        bus_op,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_pattern,
  input logic [DATA_W-1:0] cfg_mask,
  input logic [3:0]        cfg_op,
  input logic [LEN_W-1:0]  cfg_plen_m1,
  input logic              trig_stb,
  input logic              trig_out
);
  // R1
  stb_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_stb |-> $past(bus_vld));

  // R2
  stb_addr_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_stb |-> ($past(bus_addr) == $past(cfg_addr)));

  // R3
  stb_data_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_stb |-> ((($past(bus_data) ^ $past(cfg_pattern)) & ~$past(cfg_mask)) == '0));

  // R7
  stb_op_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_stb |-> ($past(cfg_op) <= 4'd8));

  // R6
  stb_op_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_stb && ($past(cfg_op) != 4'd0)) |-> ($past(bus_op) == $past(cfg_op)));

  // R8
  out_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_stb |-> trig_out);

  // R8
  out_rise_by_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_out) |-> trig_stb);
endmodule

bind trig_matcher trig_matcher_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .PULSE_MAX (PULSE_MAX)
) u_chk (.*);

// File: tb/tb_trig_matcher.sv
`timescale 1ns/1ps
module tb_trig_matcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_vld = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [15:0] bus_data = '0;
  logic [3:0]  bus_op = '0;
  logic [31:0] cfg_addr = '0;
  logic [15:0] cfg_pattern = '0;
  logic [15:0] cfg_mask = '0;
  logic [3:0]  cfg_op = '0;
  logic [3:0]  cfg_plen_m1 = '0;
  logic        trig_stb;
  logic        trig_out;

  always #2.5 clk = ~clk;

  trig_matcher dut (.*);

  typedef struct {
    bit    stb;
    bit    out;
    string tag;
  } exp_t;

  exp_t  sb_q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  int    model_cnt = 0;
  bit    finished = 0;

  logic [31:0] t_addr = '0;
  logic [15:0] t_pat = '0;
  logic [15:0] t_mask = '0;
  logic [3:0]  t_op = '0;
  logic [3:0]  t_len = '0;

  task automatic check(string tag, string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, expv, $time);
    end
  endtask

  function automatic bit want_match(bit v, logic [31:0] a, logic [15:0] d, logic [3:0] op);
    bit op_ok;
    if (t_op == 4'd0) op_ok = 1;
    else if (t_op <= 4'd8) op_ok = (op == t_op);
    else op_ok = 0;
    return v && (a == t_addr) && (((d ^ t_pat) & ~t_mask) == 16'h0) && op_ok;
  endfunction

  // Driver: applies one bus cycle and the current settings, pushes the expectation.
  task automatic drive(string tag, bit v, logic [31:0] a, logic [15:0] d, logic [3:0] op);
    exp_t e;
    bit   m;
    @(negedge clk);
    bus_vld = v; bus_addr = a; bus_data = d; bus_op = op;
    cfg_addr = t_addr; cfg_pattern = t_pat; cfg_mask = t_mask;
    cfg_op = t_op; cfg_plen_m1 = t_len;
    m = want_match(v, a, d, op);
    if (m) model_cnt = int'(t_len) + 1;
    else if (model_cnt > 0) model_cnt--;
    e.stb = m; e.out = (model_cnt > 0); e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) drive(tag, 0, 32'h0, 16'h0, 4'd0);
  endtask

  // Monitor: compares outputs just after each edge against the queued item.
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #1;
      if (rst_n && sb_q.size() > 0) begin
        e = sb_q.pop_front();
        check(e.tag, "trig_stb", int'(trig_stb), int'(e.stb));
        check(e.tag, "trig_out", int'(trig_out), int'(e.out));
      end
    end
  end

  initial begin
    #500us;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R10: outputs low during reset
    repeat (3) @(negedge clk);
    check("R10", "trig_stb in reset", int'(trig_stb), 0);
    check("R10", "trig_out in reset", int'(trig_out), 0);
    @(negedge clk);
    rst_n = 1'b1;

    t_addr = 32'h0000_1000; t_pat = 16'hA5C3; t_mask = 16'h0; t_op = 4'd0; t_len = 4'd2;
    idle("R10", 1);
    // R1 / R8: basic match, pulse of three clocks
    drive("R1", 1, 32'h0000_1000, 16'hA5C3, 4'd3);
    idle("R8", 5);
    // R1: valid low with otherwise matching fields
    drive("R1", 0, 32'h0000_1000, 16'hA5C3, 4'd3);
    idle("R1", 2);
    // R2: address off by one
    drive("R2", 1, 32'h0000_1001, 16'hA5C3, 4'd3);
    drive("R2", 1, 32'h8000_1000, 16'hA5C3, 4'd3);
    idle("R2", 2);
    // R3: an unmasked bit differs, then the same bit is masked
    drive("R3", 1, 32'h0000_1000, 16'hA5C2, 4'd3);
    idle("R3", 4);
    t_mask = 16'h0001;
    drive("R3", 1, 32'h0000_1000, 16'hA5C2, 4'd3);
    drive("R3", 1, 32'h0000_1000, 16'h25C2, 4'd3);
    idle("R3", 4);
    // R4: all bits masked
    t_mask = 16'hFFFF;
    drive("R4", 1, 32'h0000_1000, 16'h0000, 4'd1);
    drive("R4", 1, 32'h0000_1000, 16'h5A3C, 4'd4);
    idle("R4", 4);
    // R5: any-operation code over all kinds
    t_mask = 16'h0; t_len = 4'd0;
    for (int k = 1; k <= 8; k++) drive("R5", 1, 32'h0000_1000, 16'hA5C3, 4'(k));
    idle("R5", 2);
    // R6: exact operation code
    t_op = 4'd4;
    drive("R6", 1, 32'h0000_1000, 16'hA5C3, 4'd3);
    drive("R6", 1, 32'h0000_1000, 16'hA5C3, 4'd4);
    drive("R6", 1, 32'h0000_1000, 16'hA5C3, 4'd5);
    drive("R6", 1, 32'h0000_1000, 16'hA5C3, 4'd12);
    t_op = 4'd8;
    drive("R6", 1, 32'h0000_1000, 16'hA5C3, 4'd8);
    drive("R6", 1, 32'h0000_1000, 16'hA5C3, 4'd0);
    idle("R6", 2);
    // R7: disabled codes
    t_op = 4'd9;
    for (int k = 0; k <= 9; k++) drive("R7", 1, 32'h0000_1000, 16'hA5C3, 4'(k));
    t_op = 4'd15;
    for (int k = 0; k <= 15; k++) drive("R7", 1, 32'h0000_1000, 16'hA5C3, 4'(k));
    idle("R7", 2);
    // R8: longest pulse
    t_op = 4'd0; t_len = 4'd15;
    drive("R8", 1, 32'h0000_1000, 16'hA5C3, 4'd2);
    idle("R8", 18);
    // R9: restart while active
    t_len = 4'd3;
    drive("R9", 1, 32'h0000_1000, 16'hA5C3, 4'd6);
    idle("R9", 2);
    drive("R9", 1, 32'h0000_1000, 16'hA5C3, 4'd7);
    idle("R9", 6);
    drive("R9", 1, 32'h0000_1000, 16'hA5C3, 4'd6);
    drive("R9", 1, 32'h0000_1000, 16'hA5C3, 4'd6);
    idle("R9", 6);

    wait (sb_q.size() == 0);
    @(posedge clk);
    #2;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule